// File: doc/BRIEF.md
# Level-Masked Interrupt Priority Controller

This block gathers maskable interrupt events from eight peripheral sources and decides which one, if any, may interrupt the CPU. Each source latches its event in a factor flag. A per-source enable bit gates the flag, and a per-source 3-bit priority ranks it. Among the pending sources the block picks the one with the highest priority. It raises a registered request to the CPU only when a global interrupt-enable bit in the status word is set and that priority is strictly above the 4-bit current level, also held in the status word. While the request is raised, a vector number equal to a base plus the winning source index is presented.

The block also models the status-register side of acceptance. When the CPU acknowledges, the block saves the whole status word on a four-entry save stack, clears the enable bit and raises the level to the accepted priority. The handler is then shielded from requests of equal or lower rank. A return strobe pops the stack and restores the earlier word. Software can write the status word, the enables and the priorities, can set flags through a trigger input and can clear them through a clear mask.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the status word is 0x0000 (enable bit 0, level 0), `irqReq` is 0, `stackErr` is 0, and all flags, enables and priorities are 0.
- R2: A 1 on `srcEvent[i]` or `swTrigger[i]` sets flag i at the next edge. The flag stays set until it is cleared by `flagClr[i]` or by acceptance of source i. A set and a clear of the same flag in one cycle leave it set.
- R3: A source is pending only when both its flag and its enable bit are 1. A flag whose enable bit is 0 never causes a request.
- R4: Status bit 4 is the interrupt-enable bit. While it is 0, `irqReq` stays 0.
- R5: Status bits [11:8] hold the current level. A pending source can raise a request only if its 3-bit priority, zero-extended to 4 bits, is strictly greater than that level.
- R6: The winner is the pending source with the highest priority. On a tie the lowest index wins. `irqVector` equals `VEC_BASE` (default 0x40) plus the winner's index.
- R7: `irqReq` is registered. It rises one edge after the request condition holds, and it is 0 in the cycle after an acknowledge that was taken.
- R8: `irqAck` while `irqReq` is 1 accepts the request. The status word is pushed first. Then bit 4 is cleared, bits [11:8] are loaded with the accepted priority, and the accepted source's flag is cleared.
- R9: `retStrobe` pops the save stack and restores the full saved status word, so nested returns restore in reverse order of acceptance.
- R10: The save stack holds 4 words. An acceptance while it is full, or a return while it is empty, sets the sticky `stackErr` and leaves the status word unchanged. An acceptance while full still clears the source's flag.
- R11: When `retStrobe` and a valid acknowledge fall in the same cycle, the return is performed and the acknowledge is ignored, so the request stays raised and no flag is cleared. An acceptance or return overrides a software status write in the same cycle.
- R12: `statusWe` loads the full status word from `statusData`. `enWe` loads all enable bits from `enData`. `prioWe` loads `prioData` into the priority of source `prioSel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcEvent | input | 8 | Peripheral event pulses, one per source |
| swTrigger | input | 8 | Software flag-set mask |
| flagClr | input | 8 | Software flag-clear mask |
| enWe | input | 1 | Enable register write strobe |
| enData | input | 8 | New enable bits |
| prioWe | input | 1 | Priority write strobe |
| prioSel | input | 3 | Source whose priority is written |
| prioData | input | 3 | New priority value |
| statusWe | input | 1 | Software status write strobe |
| statusData | input | 16 | New status word |
| irqAck | input | 1 | CPU acknowledge of the raised request |
| retStrobe | input | 1 | Return-from-interrupt event |
| irqReq | output | 1 | Registered request to the CPU |
| irqVector | output | 8 | Vector number of the requested source |
| statusWord | output | 16 | Current status word |
| stackErr | output | 1 | Sticky save-stack overflow/underflow flag |

## Verification
Two kinds of collision are provoked. In the first, a return and an acknowledge are driven in the same cycle while a nested request is raised and the stack is not empty. The pop must restore the saved word, the request must stay raised, and the source's flag must survive. In the second, a peripheral event arrives on the very source being acknowledged. The flag must remain set, and this is judged at the ports: once software re-enables interrupts, the same vector must be requested again. A behavioural reference model with a queue for the save stack is stepped on every edge, and outputs are compared on each falling edge.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int STATUS_W = 16;
  localparam int IE_BIT   = 4;
  localparam int LVL_LO   = 8;
  localparam int LVL_W    = 4;

  typedef struct packed {
    logic push;     // acceptance: save status, raise level
    logic pop;      // return: restore saved status
    logic swWrite;  // software status load
    logic clrFlag;  // clear the accepted source's flag
  } ctrlStrobe_t;
endpackage

// File: rtl/irqc_resolver.sv
module irqc_resolver #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        pending,
  input  logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic                      winValid,
  output logic [IDX_W-1:0]          winIdx,
  output logic [PRIO_W-1:0]         winPrio
);
  // Strictly-greater replacement keeps the lowest index on a tie.
  always_comb begin
    winValid = 1'b0;
    winIdx   = '0;
    winPrio  = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (!winValid || prioFlat[i*PRIO_W +: PRIO_W] > winPrio)) begin
        winValid = 1'b1;
        winIdx   = IDX_W'(i);
        winPrio  = prioFlat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winIdx,
  input  logic [PRIO_W-1:0]  winPrio,
  input  logic               statusIe,
  input  logic [LVL_W-1:0]   statusLevel,
  input  logic               irqAck,
  input  logic               retStrobe,
  input  logic               statusWe,
  output ctrlStrobe_t        strobes,
  output logic [IDX_W-1:0]   accIdx,
  output logic [PRIO_W-1:0]  accPrio,
  output logic               irqReq,
  output logic [VEC_W-1:0]   irqVector
);
  logic reqQ;
  logic [IDX_W-1:0]  idxQ;
  logic [PRIO_W-1:0] prioQ;
  logic reqCond;
  logic ackTaken;

  assign reqCond  = winValid && statusIe && (LVL_W'(winPrio) > statusLevel);
  assign ackTaken = irqAck && reqQ && !retStrobe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ  <= 1'b0;
      idxQ  <= '0;
      prioQ <= '0;
    end else begin
      reqQ  <= reqCond && !ackTaken;
      idxQ  <= winIdx;
      prioQ <= winPrio;
    end
  end

  always_comb begin
    strobes.pop     = retStrobe;
    strobes.push    = ackTaken;
    strobes.clrFlag = ackTaken;
    strobes.swWrite = statusWe && !retStrobe && !ackTaken;
  end

  assign accIdx    = idxQ;
  assign accPrio   = prioQ;
  assign irqReq    = reqQ;
  assign irqVector = VEC_BASE + VEC_W'(idxQ);

  // R7
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAck && irqReq && !retStrobe |=> !irqReq);
  // R4
  req_needs_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(statusIe));
  // R5
  level_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReq) |-> $past(LVL_W'(winPrio) > statusLevel));
  // R11
  ret_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    retStrobe |-> !strobes.push && !strobes.swWrite);
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W      = $clog2(NUM_SRC),
  localparam int PTR_W      = $clog2(STACK_DEPTH),
  localparam int CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrlStrobe_t               strobes,
  input  logic [IDX_W-1:0]          accIdx,
  input  logic [PRIO_W-1:0]         accPrio,
  input  logic [NUM_SRC-1:0]        srcEvent,
  input  logic [NUM_SRC-1:0]        swTrigger,
  input  logic [NUM_SRC-1:0]        flagClr,
  input  logic                      enWe,
  input  logic [NUM_SRC-1:0]        enData,
  input  logic                      prioWe,
  input  logic [IDX_W-1:0]          prioSel,
  input  logic [PRIO_W-1:0]         prioData,
  input  logic [STATUS_W-1:0]       statusData,
  output logic [NUM_SRC-1:0]        pending,
  output logic [NUM_SRC*PRIO_W-1:0] prioFlat,
  output logic [STATUS_W-1:0]       statusQ,
  output logic                      stackErr
);
  logic [NUM_SRC-1:0] flagQ;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] ackMask;
  logic [STATUS_W-1:0] saveMem [STACK_DEPTH];
  logic [CNT_W-1:0] depthQ;
  logic stackFull, stackEmpty;
  logic [STATUS_W-1:0] enteredStatus;

  assign ackMask    = strobes.clrFlag ? (NUM_SRC'(1) << accIdx) : '0;
  assign pending    = flagQ & enQ;
  assign stackFull  = (depthQ == CNT_W'(STACK_DEPTH));
  assign stackEmpty = (depthQ == '0);

  always_comb begin
    enteredStatus = statusQ;
    enteredStatus[IE_BIT] = 1'b0;
    enteredStatus[LVL_LO +: LVL_W] = LVL_W'(accPrio);
  end

  // Set beats clear so an event landing with its own clear is kept.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ <= '0;
      enQ   <= '0;
    end else begin
      flagQ <= (flagQ & ~flagClr & ~ackMask) | srcEvent | swTrigger;
      if (enWe) enQ <= enData;
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gPrio
    logic [PRIO_W-1:0] prioQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prioQ <= '0;
      else if (prioWe && prioSel == IDX_W'(g)) prioQ <= prioData;
    end
    assign prioFlat[g*PRIO_W +: PRIO_W] = prioQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ  <= '0;
      depthQ   <= '0;
      stackErr <= 1'b0;
      for (int i = 0; i < STACK_DEPTH; i++) saveMem[i] <= '0;
    end else if (strobes.pop) begin
      if (stackEmpty) stackErr <= 1'b1;
      else begin
        statusQ <= saveMem[PTR_W'(depthQ - 1'b1)];
        depthQ  <= depthQ - 1'b1;
      end
    end else if (strobes.push) begin
      if (stackFull) stackErr <= 1'b1;
      else begin
        saveMem[PTR_W'(depthQ)] <= statusQ;
        depthQ  <= depthQ + 1'b1;
        statusQ <= enteredStatus;
      end
    end else if (strobes.swWrite) begin
      statusQ <= statusData;
    end
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);
  // R10
  pop_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop && stackEmpty |=> stackErr && $stable(statusQ));
  // R8
  push_clears_ie_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push && !stackFull |=> !statusQ[IE_BIT]);
  // R10
  push_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push && stackFull |=> $stable(statusQ));
endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int PRIO_W      = 3,
  parameter int STACK_DEPTH = 4,
  parameter int VEC_W       = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h40,
  localparam int IDX_W      = $clog2(NUM_SRC)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_SRC-1:0]  srcEvent,
  input  logic [NUM_SRC-1:0]  swTrigger,
  input  logic [NUM_SRC-1:0]  flagClr,
  input  logic                enWe,
  input  logic [NUM_SRC-1:0]  enData,
  input  logic                prioWe,
  input  logic [IDX_W-1:0]    prioSel,
  input  logic [PRIO_W-1:0]   prioData,
  input  logic                statusWe,
  input  logic [STATUS_W-1:0] statusData,
  input  logic                irqAck,
  input  logic                retStrobe,
  output logic                irqReq,
  output logic [VEC_W-1:0]    irqVector,
  output logic [STATUS_W-1:0] statusWord,
  output logic                stackErr
);
  ctrlStrobe_t strobes;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC*PRIO_W-1:0] prioFlat;
  logic winValid;
  logic [IDX_W-1:0] winIdx, accIdx;
  logic [PRIO_W-1:0] winPrio, accPrio;
  logic [STATUS_W-1:0] statusQ;

  irqc_resolver #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_resolver (
    .pending(pending), .prioFlat(prioFlat),
    .winValid(winValid), .winIdx(winIdx), .winPrio(winPrio));

  irqc_ctrl #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winIdx(winIdx), .winPrio(winPrio),
    .statusIe(statusQ[IE_BIT]), .statusLevel(statusQ[LVL_LO +: LVL_W]),
    .irqAck(irqAck), .retStrobe(retStrobe), .statusWe(statusWe),
    .strobes(strobes), .accIdx(accIdx), .accPrio(accPrio),
    .irqReq(irqReq), .irqVector(irqVector));

  irqc_datapath #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accIdx(accIdx), .accPrio(accPrio),
    .srcEvent(srcEvent), .swTrigger(swTrigger), .flagClr(flagClr),
    .enWe(enWe), .enData(enData), .prioWe(prioWe), .prioSel(prioSel), .prioData(prioData),
    .statusData(statusData), .pending(pending), .prioFlat(prioFlat),
    .statusQ(statusQ), .stackErr(stackErr));

  assign statusWord = statusQ;
endmodule

// File: tb/irq_level_ctrl_bench.sv
module irq_level_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] srcEvent = '0, swTrigger = '0, flagClr = '0, enData = '0;
  logic enWe = 1'b0, prioWe = 1'b0, statusWe = 1'b0, irqAck = 1'b0, retStrobe = 1'b0;
  logic [2:0] prioSel = '0, prioData = '0;
  logic [15:0] statusData = '0;
  logic irqReq, stackErr;
  logic [7:0] irqVector;
  logic [15:0] statusWord;

  irq_level_ctrl u_irq_level_ctrl (.*);

  always #4 clk = ~clk; // 125 MHz

  int checks = 0, fails = 0, cycles = 0;
  string phase = "R1";
  bit started = 0;

  // Behavioural reference model
  bit [7:0] mFlag, mEn;
  int mPrio[8];
  bit [15:0] mStat;
  bit [15:0] mStack[$];
  bit mErr, mReq;
  int mIdx, mWinPrio;

  always @(posedge clk) begin
    int best, bp;
    bit cond, ackE;
    bit [7:0] nf;
    if (!rstN) begin
      mFlag = 0; mEn = 0; mStat = 0; mStack.delete(); mErr = 0; mReq = 0;
      mIdx = 0; mWinPrio = 0;
      foreach (mPrio[k]) mPrio[k] = 0;
    end else begin
      best = -1; bp = 0;
      for (int i = 0; i < 8; i++)
        if (mFlag[i] && mEn[i] && (best < 0 || mPrio[i] > bp)) begin best = i; bp = mPrio[i]; end
      cond = (best >= 0) && mStat[4] && (bp > int'(mStat[11:8]));
      ackE = irqAck && mReq && !retStrobe;
      nf = mFlag & ~flagClr;
      if (ackE) nf[mIdx] = 1'b0;
      nf = nf | srcEvent | swTrigger;
      if (retStrobe) begin
        if (mStack.size() == 0) mErr = 1;
        else mStat = mStack.pop_back();
      end else if (ackE) begin
        if (mStack.size() == 4) mErr = 1;
        else begin
          mStack.push_back(mStat);
          mStat[4] = 1'b0;
          mStat[11:8] = 4'(mWinPrio);
        end
      end else if (statusWe) mStat = statusData;
      if (enWe) mEn = enData;
      if (prioWe) mPrio[prioSel] = int'(prioData);
      mReq = cond && !ackE;
      mIdx = (best >= 0) ? best : 0;
      mWinPrio = (best >= 0) ? bp : 0;
      mFlag = nf;
    end
    started = 1;
    cycles++;
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk(phase, "irqReq", int'(irqReq), int'(mReq));
      chk(phase, "statusWord", int'(statusWord), int'(mStat));
      chk(phase, "stackErr", int'(stackErr), int'(mErr));
      if (mReq) chk(phase, "irqVector", int'(irqVector), 'h40 + mIdx);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearIns();
    srcEvent = '0; swTrigger = '0; flagClr = '0; enWe = 0; prioWe = 0;
    statusWe = 0; irqAck = 0; retStrobe = 0;
  endtask

  task automatic setPrio(int s, int p);
    prioWe = 1; prioSel = 3'(s); prioData = 3'(p); tick(); clearIns();
  endtask
  task automatic setEn(logic [7:0] m);
    enWe = 1; enData = m; tick(); clearIns();
  endtask
  task automatic wrStat(logic [15:0] w);
    statusWe = 1; statusData = w; tick(); clearIns();
  endtask
  task automatic event_(logic [7:0] m);
    srcEvent = m; tick(); clearIns();
  endtask
  task automatic ackNow();
    irqAck = 1; tick(); clearIns();
  endtask
  task automatic retNow();
    retStrobe = 1; tick(); clearIns();
  endtask
  task automatic waitReq();
    for (int i = 0; i < 10 && !irqReq; i++) tick();
  endtask
  task automatic doReset();
    rstN = 0; tick(2); rstN = 1; tick();
  endtask

  initial begin
    tick(2); rstN = 1; tick();
    phase = "R1";
    chk("R1", "reset status", int'(statusWord), 0);
    chk("R1", "reset req", int'(irqReq), 0);

    phase = "R12"; setPrio(3, 5); setPrio(1, 5); setPrio(6, 7); setEn(8'h0A);
    wrStat(16'h0010);
    chk("R12", "status load", int'(statusWord), 'h0010);

    phase = "R3"; event_(8'h40); tick(3);
    chk("R3", "disabled src no req", int'(irqReq), 0);
    flagClr = 8'h40; tick(); clearIns();

    phase = "R6"; event_(8'h0A); tick();
    chk("R6", "tie vector", int'(irqVector), 'h41);
    phase = "R8"; ackNow();
    chk("R7", "req drops after ack", int'(irqReq), 0);
    chk("R8", "status after accept", int'(statusWord), 'h0500);
    phase = "R9"; retNow();
    chk("R9", "restore", int'(statusWord), 'h0010);
    waitReq();
    chk("R6", "next winner", int'(irqVector), 'h43);
    ackNow(); retNow(); tick(2);

    phase = "R5"; wrStat(16'h0510); setEn(8'h4A); event_(8'h08); tick(3);
    chk("R5", "equal level held", int'(irqReq), 0);
    event_(8'h40); tick(2);
    chk("R5", "higher prio passes", int'(irqReq), 1);
    phase = "R4"; wrStat(16'h0500); tick(2);
    chk("R4", "ie=0 blocks", int'(irqReq), 0);

    phase = "R2"; flagClr = 8'hFF; tick(); clearIns(); wrStat(16'h0010);
    swTrigger = 8'h08; tick(); clearIns(); waitReq();
    chk("R2", "sw trigger req", int'(irqVector), 'h43);
    irqAck = 1; srcEvent = 8'h08; tick(); clearIns();
    wrStat(16'h0010); waitReq();
    chk("R2", "set beats ack clear", int'(irqReq), 1);
    ackNow(); retNow();

    // Nesting and same-cycle return/ack
    phase = "R11"; doReset();
    setPrio(0, 2); setPrio(5, 6); setEn(8'h21); wrStat(16'h0010);
    event_(8'h01); waitReq(); ackNow();
    wrStat(16'h0210); event_(8'h20); waitReq();
    irqAck = 1; retStrobe = 1; tick(); clearIns();
    chk("R11", "ret wins status", int'(statusWord), 'h0010);
    chk("R11", "req kept", int'(irqReq), 1);
    ackNow(); retNow(); tick(2);

    // Overflow: five nested acceptances
    phase = "R10"; doReset();
    for (int s = 0; s < 5; s++) setPrio(s, s + 1);
    setEn(8'h1F); wrStat(16'h0010);
    for (int s = 0; s < 5; s++) begin
      event_(8'(1 << s)); waitReq(); ackNow();
      if (s < 4) wrStat(16'(16'h0010 | (s + 1) << 8));
    end
    chk("R10", "overflow err", int'(stackErr), 1);
    chk("R10", "overflow status kept", int'(statusWord), 'h0410);
    phase = "R9";
    for (int s = 3; s >= 0; s--) begin
      retNow();
      chk("R9", "nested restore", int'(statusWord), (s == 0) ? 'h0010 : ('h0010 | (s << 8)));
    end
    phase = "R10"; doReset(); retNow();
    chk("R10", "underflow err", int'(stackErr), 1);
    chk("R10", "underflow status", int'(statusWord), 0);
    tick(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    checks++; fails++;
    $display("FAIL watchdog actual %0d expected below 20000", cycles);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule